// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

A serial encoder for a four-state convolutional code of rate one half and constraint length three. Each information bit accepted on the input handshake produces exactly one two-bit code symbol on the output handshake. The symbol depends on the new bit and on the two bits accepted before it, which form the encoder state.

The output stage is a single register. The symbol for a bit accepted on one clock edge is presented on the following cycle and held until the consumer takes it. A flush request ends a frame. It makes the encoder feed itself two zero bits, so that the trellis returns to its all-zero state. The last of the two tail symbols is marked so the consumer can find the frame boundary.

Top module: `conv_enc_r2`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` = 0, `out_last` = 0 and `in_ready` = 1, and the state is 00 (s1 = 0, s2 = 0).
- R2: For an encoded bit u in state (s1, s2), where s1 is the most recent earlier bit, `out_sym[1]` (the first bit sent) is u^s2 and `out_sym[0]` (the second) is u^s1^s2. Afterwards s1 takes u and s2 takes the old s1. For example, state 00 with u = 1 gives 2'b11, and state 10 with u = 0 gives 2'b01.
- R3: The symbol for a bit accepted at a clock edge (`in_valid` & `in_ready` & !`flush`) appears with `out_valid` = 1 in the cycle after that edge.
- R4: While `out_valid` = 1 and `out_ready` = 0, `out_sym` and `out_last` hold their values and `in_ready` is 0.
- R5: Each accepted bit produces exactly one symbol, in acceptance order, and no symbol is produced without an accepted bit or a tail injection.
- R6: A flush accepted at an edge (`flush` & `in_ready`) produces two symbols encoded with u = 0. `in_ready` stays low in the cycle after acceptance, and the state is 00 once the second tail symbol has been produced.
- R7: `out_last` = 1 exactly with the second tail symbol of a flush, and 0 with every other symbol.
- R8: When `flush` and `in_valid` are both high at an accepting edge, the flush is taken and `in_bit` is discarded.
- R9: While `in_valid` = 0 and `flush` = 0, `in_bit` has no effect on the state or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An information bit is offered |
| in_bit | input | 1 | Information bit |
| flush | input | 1 | Request two tail zeros to close the frame |
| in_ready | output | 1 | A bit or a flush can be taken this cycle |
| out_valid | output | 1 | `out_sym` holds a symbol |
| out_ready | input | 1 | Consumer takes the symbol |
| out_sym | output | 2 | Code symbol, bit 1 sent first |
| out_last | output | 1 | Symbol is the final tail symbol |

## Verification
On every cycle, the assertions check that a stalled symbol stays stable and blocks input, that reset clears the output stage, that a flush shuts the input for one cycle, and that the state is zero whenever the final tail symbol is shown. Only the bench scenarios can show that the code values match the trellis and that symbols stay in order under random backpressure. They also cover a flush that collides with valid data and the bits that are ignored while nothing is offered. These are compared against a reference model that the bench keeps on its own.

// File: rtl/conv_enc_r2.sv
module conv_enc_r2 #(
  parameter logic [2:0] GEN_A = 3'b101,
  parameter logic [2:0] GEN_B = 3'b111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       flush,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_sym,
  output logic       out_last
);
  logic [1:0] state;
  logic       tail_pend;
  logic       step, take_bit, take_flush, inject, adv, u;
  logic [2:0] taps;

  assign step       = !out_valid || out_ready;
  assign in_ready   = step && !tail_pend;
  assign take_flush = flush && in_ready;
  assign take_bit   = in_valid && in_ready && !flush;
  assign inject     = tail_pend && step;
  assign adv        = take_bit || take_flush || inject;
  assign u          = take_bit ? in_bit : 1'b0;
  assign taps       = {u, state[1], state[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= 2'b00;
      tail_pend <= 1'b0;
      out_valid <= 1'b0;
      out_sym   <= 2'b00;
      out_last  <= 1'b0;
    end else if (adv) begin
      state     <= {u, state[1]};
      tail_pend <= take_flush;
      out_valid <= 1'b1;
      out_sym   <= {^(taps & GEN_A), ^(taps & GEN_B)};
      out_last  <= inject;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_enc_r2_chk.sv
module conv_enc_r2_chk (
  input logic       clk,
  input logic       rst,
  input logic       flush,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_sym,
  input logic       out_last,
  input logic [1:0] state
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last && in_ready && state == 2'b00));

  a_r4_hold_symbol: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_last)));

  a_r4_block_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_flush_closes_input: assert property (@(posedge clk) disable iff (rst)
    (flush && in_ready) |=> (!in_ready && out_valid));

  a_r6_tail_zero_state: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> state == 2'b00);

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

bind conv_enc_r2 conv_enc_r2_chk u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
  .out_last(out_last), .state(state)
);

// File: tb/conv_enc_r2_test.sv
module conv_enc_r2_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       flush = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_sym;
  logic       out_last;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic m_s1 = 1'b0, m_s2 = 1'b0;
  logic [2:0] expq[$];
  logic       held_v = 1'b0;
  logic [2:0] held;

  conv_enc_r2 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .flush(flush),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic u, input logic last);
    logic [1:0] s;
    s = {u ^ m_s2, u ^ m_s1 ^ m_s2};
    m_s2 = m_s1;
    m_s1 = u;
    return {s, last};
  endfunction

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (held_v) begin
        check(out_valid && {out_sym, out_last} == held, "R4 hold", {out_sym, out_last}, held);
        held_v = 1'b0;
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R4 in_ready", in_ready, 0);
        held_v = 1'b1;
        held = {out_sym, out_last};
      end else if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5 extra symbol", {out_sym, out_last}, 0);
        end else begin
          logic [2:0] e;
          e = expq.pop_front();
          check(out_sym == e[2:1], "R2 symbol", out_sym, e[2:1]);
          check(out_last == e[0], "R7 last flag", out_last, e[0]);
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    expq.push_back(model(b, 1'b0));
    @(posedge clk); #1;
    in_valid = 1'b0; in_bit = ~b;
    check(out_valid == 1'b1, "R3 valid after accept", out_valid, 1);
  endtask

  task automatic send_flush(input bit with_data);
    @(negedge clk);
    flush = 1'b1;
    if (with_data) begin in_valid = 1'b1; in_bit = 1'b1; end
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    expq.push_back(model(1'b0, 1'b0));
    expq.push_back(model(1'b0, 1'b1));
    @(posedge clk); #1;
    flush = 1'b0; in_valid = 1'b0;
    check(!in_ready, with_data ? "R8 flush wins" : "R6 input closed", in_ready, 0);
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 200) begin @(negedge clk); n++; end
    #3;
    check(expq.size() == 0, "R5 all symbols seen", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(!out_last, "R1 out_last", out_last, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);
    rst = 1'b0;

    begin
      logic [8:0] pat = 9'b010011101;
      for (int i = 8; i >= 0; i--) send_bit(pat[i]);
    end
    send_flush(1'b0);
    drain();

    send_bit(1'b1);
    send_bit(1'b0);
    send_flush(1'b1);
    drain();

    send_bit(1'b1);
    send_bit(1'b1);
    drain();
    repeat (6) begin
      @(negedge clk);
      in_bit = ~in_bit;
    end
    #3;
    check(!out_valid, "R9 no output when idle", out_valid, 0);
    send_bit(1'b0);
    send_bit(1'b0);
    drain();

    bp_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send_bit(lfsr[1] ^ lfsr[6]);
      if (i % 13 == 12) send_flush(i[0]);
    end
    send_flush(1'b0);
    drain();
    bp_on = 1'b0;

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R1 mid-run reset", out_valid, 0);
    rst = 1'b0;
    m_s1 = 1'b0; m_s2 = 1'b0;
    send_bit(1'b1);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule